// File: doc/BRIEF.md
# Half-Bridge Controller Serial Slave with Frame-Length Check

This block is the serial command port of a three-channel half-bridge driver controller. A host drives chip select, serial clock and serial data; the block brings those pins into the system clock domain through two-flop synchronizers and finds their edges there. Data is sampled on each rising serial clock edge, least significant bit first. On the same edges a 16-bit shift register moves the controller's status word out, also least significant bit first.

When chip select falls, the status word is copied into the shift register, so the thermal-warning bit sits on the serial output before any clock edge. Bits taken in from the serial input follow the status word out, 16 clocks later, which allows several devices to share one daisy-chained frame. When chip select rises, the block looks at the number of clock edges it counted. The last 16 received bits go into the control register, and a one-cycle valid-frame pulse tells the fault logic to clear its latched faults, only if that number is a nonzero multiple of 16 and the serial clock is low. Any other frame has no effect.

Top module: `hb_spi_slave`

## Requirements
- R1: Serial input is sampled on each rising serial clock edge while chip select is low. The first bit shifted in lands in control bit 0 of a 16-bit frame.
- R2: At the chip-select rising edge, a nonzero count that is a multiple of 16 commits the last 16 received bits to the control register. For a 32- or 48-bit frame these are the final 16 bits shifted in.
- R3: A count of 0, or a count that is not a multiple of 16 (for example 15 or 17), leaves the control register unchanged.
- R4: A frame whose serial clock is still high at the chip-select rising edge is invalid and commits nothing.
- R5: `frame_ok_o` is high for exactly one system clock cycle per valid frame and stays low for every invalid frame.
- R6: `sdo_oe_o` is low and `sdo_o` is 0 whenever chip select is high.
- R7: At the chip-select falling edge, `status_i` is loaded. Its bit 0 (thermal warning) appears on `sdo_o` before any serial clock edge.
- R8: Before rising edge k+1, `sdo_o` shows status bit k for k < 16, and after that the serial input bit received 16 edges earlier.
- R9: Control bits 7 to 12 are ignored and always read 0. Bit 0 is status reset, bits 1 to 6 are the low/high driver commands of channels 1 to 3 in pairs, bit 13 selects the overcurrent delay, bit 14 enables underload shutdown, and bit 15 enables overvoltage lockout.
- R10: After reset, `ctrl_o` is 0, `frame_ok_o` is 0 and `sdo_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, 0 when not enabled |
| sdo_oe_o | output | 1 | Output enable for the external tristate buffer |
| status_i | input | 16 | Status word to report |
| ctrl_o | output | 16 | Committed control word |
| frame_ok_o | output | 1 | One-cycle pulse on a valid frame, used to clear faults |

## Verification
The assertions take for granted that the system clock runs at least four times faster than the serial clock, so that every high and low serial clock phase lasts at least two system cycles after synchronization. They also assume that serial data is stable around each rising edge, and that chip select never moves in the same synchronized cycle as a serial clock rising edge. The stimulus holds each serial clock phase for four system cycles and changes data only while the clock is low. It also leaves four quiet cycles between every chip-select edge and the nearest serial clock edge, so all recorded expectations stay within these assumptions.

// File: rtl/hb_spi_pkg.sv
package hb_spi_pkg;
  localparam int FRAME_W = 16;
  localparam int CNT_W   = $clog2(FRAME_W);
  // control field positions
  localparam int C_SRR   = 0;
  localparam int C_DRV_LO = 1;
  localparam int C_DRV_HI = 6;
  localparam int C_OCD   = 13;
  localparam int C_ULSD  = 14;
  localparam int C_OVLO  = 15;
  function automatic logic [FRAME_W-1:0] keep_mask();
    logic [FRAME_W-1:0] m;
    m = '0;
    m[C_SRR] = 1'b1;
    for (int i = C_DRV_LO; i <= C_DRV_HI; i++) m[i] = 1'b1;
    m[C_OCD] = 1'b1;
    m[C_ULSD] = 1'b1;
    m[C_OVLO] = 1'b1;
    return m;
  endfunction
  localparam logic [FRAME_W-1:0] CTRL_KEEP = keep_mask();
endpackage

// File: rtl/hb_spi_sync.sv
module hb_spi_sync #(
  parameter int           W   = 3,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[g]   <= RST[g];
        s2_q[g]   <= RST[g];
        prev_q[g] <= RST[g];
      end else begin
        s1_q[g]   <= pin_i[g];
        s2_q[g]   <= s1_q[g];
        prev_q[g] <= s2_q[g];
      end
    end
    assign rise_o[g] = s2_q[g] & ~prev_q[g];
    assign fall_o[g] = ~s2_q[g] & prev_q[g];
  end

  assign lvl_o = s2_q;
endmodule

// File: rtl/hb_spi_shifter.sv
module hb_spi_shifter
  import hb_spi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_s_i,
  input  logic               cs_fall_i,
  input  logic               cs_rise_i,
  input  logic               sck_rise_i,
  input  logic               sdi_s_i,
  input  logic [FRAME_W-1:0] status_i,
  output logic [FRAME_W-1:0] rx_word_o,
  output logic               sdo_o,
  output logic               sdo_oe_o
);
  logic [FRAME_W-1:0] sr_q;
  logic               oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (cs_fall_i) begin
      sr_q <= status_i;
    end else if (sck_rise_i && !cs_s_i) begin
      sr_q <= {sdi_s_i, sr_q[FRAME_W-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        oe_q <= 1'b0;
    else if (cs_fall_i) oe_q <= 1'b1;
    else if (cs_rise_i) oe_q <= 1'b0;
  end

  assign rx_word_o = sr_q;
  assign sdo_oe_o  = oe_q;
  assign sdo_o     = oe_q & sr_q[0];

  a_r6_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> !sdo_oe_o);
  a_r7_status_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> (sdo_oe_o && sdo_o == $past(status_i[0])));
  a_r6_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);
endmodule

// File: rtl/hb_spi_frame_chk.sv
module hb_spi_frame_chk
  import hb_spi_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_s_i,
  input  logic cs_fall_i,
  input  logic cs_rise_i,
  input  logic sck_s_i,
  input  logic sck_rise_i,
  output logic commit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (cs_fall_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (sck_rise_i && !cs_s_i) begin
      cnt_q  <= cnt_q + 1'b1;
      seen_q <= 1'b1;
    end
  end

  // count modulo frame width; seen_q rules out the empty frame
  assign commit_o = cs_rise_i & seen_q & (cnt_q == '0) & ~sck_s_i;

  a_r3_no_count_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s_i && !cs_fall_i) |=> $stable(cnt_q));
endmodule

// File: rtl/hb_spi_slave.sv
module hb_spi_slave
  import hb_spi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sck_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  output logic               sdo_oe_o,
  input  logic [FRAME_W-1:0] status_i,
  output logic [FRAME_W-1:0] ctrl_o,
  output logic               frame_ok_o
);
  localparam int PIN_W = 3;
  localparam int P_CS = 0, P_SCK = 1, P_SDI = 2;

  logic [PIN_W-1:0] lvl, rise, fall;
  logic [FRAME_W-1:0] rx_word, ctrl_q;
  logic commit, frame_ok_q;

  hb_spi_sync #(.W(PIN_W), .RST(3'b001)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({sdi_i, sck_i, cs_ni}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  hb_spi_shifter i_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_s_i     (lvl[P_CS]),
    .cs_fall_i  (fall[P_CS]),
    .cs_rise_i  (rise[P_CS]),
    .sck_rise_i (rise[P_SCK]),
    .sdi_s_i    (lvl[P_SDI]),
    .status_i   (status_i),
    .rx_word_o  (rx_word),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o)
  );

  hb_spi_frame_chk i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_s_i     (lvl[P_CS]),
    .cs_fall_i  (fall[P_CS]),
    .cs_rise_i  (rise[P_CS]),
    .sck_s_i    (lvl[P_SCK]),
    .sck_rise_i (rise[P_SCK]),
    .commit_o   (commit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      frame_ok_q <= 1'b0;
    end else begin
      frame_ok_q <= commit;
      if (commit) ctrl_q <= rx_word & CTRL_KEEP;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign frame_ok_o = frame_ok_q;

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ok_o |=> !frame_ok_o);
  a_r3_hold_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise[P_CS] |=> $stable(ctrl_o));
  a_r2_commit_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ok_o |-> ctrl_o == ($past(rx_word) & CTRL_KEEP));
  a_r4_sck_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ok_o |-> !$past(lvl[P_SCK]));
  a_r6_oe_follows_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl[P_CS] && !rise[P_CS]) |-> !sdo_oe_o);
endmodule

// File: tb/test_hb_spi_slave.sv
module test_hb_spi_slave;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 4;
  localparam int NV = 8;
  localparam int VB [NV] = '{16, 16, 15, 17, 32, 0, 48, 16};
  localparam logic [47:0] VD [NV] = '{
    48'h0000_0000_A5C3, 48'h0000_0000_FFFF, 48'h0000_0000_7FFF,
    48'h0000_0001_FFFF, 48'h0000_1234_ABCD, 48'h0000_0000_0000,
    48'hC07E_5555_AAAA, 48'h0000_0000_8001};
  localparam logic [15:0] VS [NV] = '{
    16'h0001, 16'hF07E, 16'h8000, 16'h1235, 16'h9AC7, 16'h0001, 16'h6E2B, 16'hFFFF};
  localparam bit VH [NV] = '{0, 0, 0, 0, 0, 0, 0, 1};
  localparam logic [15:0] KEEP = 16'hE07F;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sck = 0, sdi = 0;
  logic [15:0] status = '0;
  logic sdo, sdo_oe, frame_ok;
  logic [15:0] ctrl;

  int applied = 0, miscompares = 0, pulses = 0, cycles = 0;
  logic [15:0] exp_ctrl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_spi_slave i_hb_spi_slave (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .status_i(status), .ctrl_o(ctrl),
    .frame_ok_o(frame_ok));

  always @(posedge clk) begin
    if (frame_ok) pulses++;
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int nb, input logic [47:0] d, input logic [15:0] st, input bit hi_end);
    int p0;
    bit ok;
    logic [15:0] e;
    p0 = pulses;
    status = st;
    wt(PH);
    cs_n = 0;
    wt(PH);
    chk("R7 sdo before clocks", {15'd0, sdo}, {15'd0, st[0]});
    for (int j = 0; j < nb; j++) begin
      sdi = d[j];
      wt(PH);
      e = {15'd0, (j < 16) ? st[j] : d[j-16]};
      if (j > 0) chk("R8 sdo stream", {15'd0, sdo}, e);
      sck = 1;
      wt(PH);
      if (!(hi_end && j == nb - 1)) sck = 0;
    end
    wt(PH);
    cs_n = 1;
    wt(2 * PH);
    sck = 0;
    ok = (nb != 0) && (nb % 16 == 0) && !hi_end;
    if (ok) exp_ctrl = d[nb-16 +: 16] & KEEP;
    chk(ok ? "R2 commit" : (hi_end ? "R4 sck high" : "R3 hold"), ctrl, exp_ctrl);
    chk("R5 pulse count", 16'(pulses - p0), ok ? 16'd1 : 16'd0);
    chk("R6 tristate", {14'd0, sdo_oe, sdo}, 16'd0);
  endtask

  initial begin
    wt(3);
    chk("R10 reset ctrl", ctrl, 16'h0000);
    chk("R10 reset flags", {14'd0, sdo_oe, frame_ok}, 16'd0);
    rst_n = 1;
    wt(4);
    chk("R6 idle oe", {15'd0, sdo_oe}, 16'd0);
    for (int v = 0; v < NV; v++) frame(VB[v], VD[v], VS[v], VH[v]);
    // R1 R9: bit order and ignored field on a fresh word
    frame(16, 48'h0000_1F81, 16'h0000, 0);
    chk("R1 lsb first", ctrl, 16'h0001);
    chk("R9 ignored bits", ctrl & 16'h1F80, 16'h0000);
    // R3 after a valid word: 17 bits leaves it
    frame(17, 48'h0_0000_E07E, 16'h0002, 0);
    chk("R3 unchanged", ctrl, 16'h0001);
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule